// File: doc/BRIEF.md
# Floating-Point Widening Converter

This block takes a binary floating-point word in either 32-bit single or 64-bit double precision and re-encodes it as an 80-bit extended-precision word: one sign bit, a 15-bit exponent with bias 16383, and a 64-bit significand whose integer bit is stored rather than implied. A format select picks the source layout. A single-precision source sits in the low 32 bits of the input word. The result is registered, so it appears one clock after the input strobe.

Every source class is carried across. Normal numbers are re-biased and given an explicit integer bit. Zeros keep their sign. Infinities and NaNs receive the all-ones extended exponent, and a NaN is made quiet. Denormal sources are normalized through a leading-zero count, so the extended word always has its integer bit set unless the value is zero. Four class flags report the source's class next to the result. Widening is exact, so no rounding is involved.

Top module: `fpx_widen`

## Requirements
- R1: The output sign, out_word[79], equals the source sign (bit 31 for single, bit 63 for double) for every class.
- R2: For a single-precision normal source with biased exponent e and fraction f, out_word[78:64] = e + 16256 and out_word[63:0] = {1'b1, f, 40'b0}. For example, 100.25 (0x42C88000) becomes exponent 0x4005 with significand 0xC880000000000000.
- R3: For a double-precision normal source with biased exponent e and fraction f, out_word[78:64] = e + 15360 and out_word[63:0] = {1'b1, f, 11'b0}.
- R4: A zero source (exponent and fraction all zero) gives out_word[78:0] = 0 with the sign kept, and out_zero = 1.
- R5: An infinity (exponent all ones, fraction zero) gives exponent 0x7FFF, significand 0x8000000000000000, and out_inf = 1.
- R6: A NaN (exponent all ones, fraction nonzero) gives exponent 0x7FFF. The significand has bit 63 = 1, the source fraction is left-aligned directly below bit 63, and bit 62 (the quiet bit) is forced to 1. out_nan = 1.
- R7: A denormal source (exponent zero, fraction nonzero) is normalized. With z equal to the count of leading zeros in the fraction, the exponent is 16383 - bias - z (bias 127 or 1023) and the significand is the fraction shifted so its leading one lands at bit 63. out_denorm = 1.
- R8: out_valid is in_valid delayed by one clock. Active-low reset clears out_valid at once.
- R9: in_fmt = 0 selects single precision and in_fmt = 1 selects double. In single mode, in_word[63:32] has no effect on the result.
- R10: At most one class flag is set, and none is set for a normal source. When in_valid is low, out_word and the flags keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source word strobe |
| in_fmt | input | 1 | 0 = single (low 32 bits), 1 = double |
| in_word | input | 64 | Source floating-point word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 80 | Extended-precision result |
| out_zero | output | 1 | Source was zero |
| out_inf | output | 1 | Source was infinity |
| out_nan | output | 1 | Source was NaN |
| out_denorm | output | 1 | Source was denormal |

## Verification
The hardest cases to reach are denormals whose leading one sits at a particular depth, and the endpoints of the shift: the smallest denormal (one fraction bit, the largest shift) and the largest (all fraction bits, shift zero). Uniform random words almost never have a zero exponent. The stimulus therefore picks a class first, and for denormals it places a single leading one at a random position with random bits below it. Directed vectors cover both extreme denormals in both formats. NaNs with only the lowest fraction bit set, and single-precision words with garbage in the unused upper half, are also included as directed cases.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_BIAS   = 127;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int DP_BIAS   = 1023;
  localparam int XP_EXP_W  = 15;
  localparam int XP_SIG_W  = 64;
  localparam int XP_BIAS   = 16383;
  localparam int XP_W      = 1 + XP_EXP_W + XP_SIG_W;
  localparam int LZ_W      = $clog2(DP_FRAC_W + 1);

  typedef enum logic [2:0] {
    CL_NORM,
    CL_ZERO,
    CL_DENORM,
    CL_INF,
    CL_NAN
  } fpx_class_e;
endpackage

// File: rtl/fpx_unpack.sv
module fpx_unpack
  import fpx_pkg::*;
(
  input  logic                 fmt_dbl,
  input  logic [63:0]          word,
  output logic                 sign,
  output logic [DP_EXP_W-1:0]  exp_raw,
  output logic [DP_FRAC_W-1:0] frac,
  output logic [XP_EXP_W-1:0]  rebias,
  output fpx_class_e           cls
);
  localparam int PAD_W = DP_FRAC_W - SP_FRAC_W;
  localparam logic [XP_EXP_W-1:0] SP_REBIAS = XP_EXP_W'(XP_BIAS - SP_BIAS);
  localparam logic [XP_EXP_W-1:0] DP_REBIAS = XP_EXP_W'(XP_BIAS - DP_BIAS);

  logic exp_zero;
  logic exp_ones;
  logic frac_zero;

  always_comb begin
    if (fmt_dbl) begin
      sign     = word[63];
      exp_raw  = word[62:DP_FRAC_W];
      frac     = word[DP_FRAC_W-1:0];
      rebias   = DP_REBIAS;
      exp_ones = &word[62:DP_FRAC_W];
    end else begin
      sign     = word[31];
      exp_raw  = {{(DP_EXP_W-SP_EXP_W){1'b0}}, word[30:SP_FRAC_W]};
      frac     = {word[SP_FRAC_W-1:0], {PAD_W{1'b0}}};
      rebias   = SP_REBIAS;
      exp_ones = &word[30:SP_FRAC_W];
    end
    exp_zero  = (exp_raw == '0);
    frac_zero = (frac == '0);
  end

  always_comb begin
    if (exp_zero)      cls = frac_zero ? CL_ZERO : CL_DENORM;
    else if (exp_ones) cls = frac_zero ? CL_INF  : CL_NAN;
    else               cls = CL_NORM;
  end
endmodule

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
  parameter int W  = 52,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpx_pack.sv
module fpx_pack
  import fpx_pkg::*;
(
  input  logic                 sign,
  input  fpx_class_e           cls,
  input  logic [DP_EXP_W-1:0]  exp_raw,
  input  logic [DP_FRAC_W-1:0] frac,
  input  logic [XP_EXP_W-1:0]  rebias,
  input  logic [LZ_W-1:0]      lz,
  output logic [XP_W-1:0]      word
);
  localparam int TAIL_W = XP_SIG_W - 1 - DP_FRAC_W;

  logic [XP_EXP_W-1:0] exp_o;
  logic [XP_SIG_W-1:0] sig_o;
  logic [XP_SIG_W-1:0] den_sig;

  always_comb begin
    den_sig = {frac, {(TAIL_W + 1){1'b0}}} << lz;
  end

  always_comb begin
    exp_o = '0;
    sig_o = '0;
    unique case (cls)
      CL_ZERO: begin
        exp_o = '0;
        sig_o = '0;
      end
      CL_DENORM: begin
        exp_o = rebias - XP_EXP_W'(lz);
        sig_o = den_sig;
      end
      CL_INF: begin
        exp_o = '1;
        sig_o = {1'b1, {(XP_SIG_W-1){1'b0}}};
      end
      CL_NAN: begin
        exp_o = '1;
        sig_o = {1'b1, 1'b1, frac[DP_FRAC_W-2:0], {TAIL_W{1'b0}}};
      end
      default: begin
        exp_o = XP_EXP_W'(exp_raw) + rebias;
        sig_o = {1'b1, frac, {TAIL_W{1'b0}}};
      end
    endcase
    word = {sign, exp_o, sig_o};
  end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_fmt,
  input  logic [63:0]       in_word,
  output logic              out_valid,
  output logic [XP_W-1:0]   out_word,
  output logic              out_zero,
  output logic              out_inf,
  output logic              out_nan,
  output logic              out_denorm
);
  logic                 u_sign;
  logic [DP_EXP_W-1:0]  u_exp;
  logic [DP_FRAC_W-1:0] u_frac;
  logic [XP_EXP_W-1:0]  u_rebias;
  fpx_class_e           u_cls;
  logic [LZ_W-1:0]      u_lz;
  logic [XP_W-1:0]      p_word;

  fpx_unpack u_unpack (
    .fmt_dbl (in_fmt),
    .word    (in_word),
    .sign    (u_sign),
    .exp_raw (u_exp),
    .frac    (u_frac),
    .rebias  (u_rebias),
    .cls     (u_cls)
  );

  fpx_lzc #(.W(DP_FRAC_W), .CW(LZ_W)) u_lzc (
    .vec (u_frac),
    .cnt (u_lz)
  );

  fpx_pack u_pack (
    .sign    (u_sign),
    .cls     (u_cls),
    .exp_raw (u_exp),
    .frac    (u_frac),
    .rebias  (u_rebias),
    .lz      (u_lz),
    .word    (p_word)
  );

  // next-state
  logic            vld_nxt;
  logic            dat_en;
  logic [XP_W-1:0] word_nxt;
  logic [3:0]      flg_nxt;

  always_comb begin
    vld_nxt  = in_valid;
    dat_en   = in_valid;
    word_nxt = p_word;
    flg_nxt  = {u_cls == CL_ZERO, u_cls == CL_INF,
                u_cls == CL_NAN,  u_cls == CL_DENORM};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (dat_en) begin
      out_word <= word_nxt;
      {out_zero, out_inf, out_nan, out_denorm} <= flg_nxt;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid lost"); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("spurious valid"); // R8
  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_word[XP_W-1] == $past(in_fmt ? in_word[63] : in_word[31]))
    else $error("sign changed"); // R1
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_zero, out_inf, out_nan, out_denorm}))
    else $error("flags"); // R10
  AST_INT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> out_word[XP_SIG_W-1])
    else $error("integer bit clear"); // R7
  AST_ZERO_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_word[XP_W-2:0] == '0))
    else $error("zero encoding"); // R4
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nan) |-> (&out_word[XP_W-2:XP_SIG_W] && out_word[XP_SIG_W-2]))
    else $error("nan encoding"); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_valid) |=> $stable(out_word))
    else $error("hold"); // R10
endmodule

// File: tb/tb_fpx_widen.sv
`timescale 1ns/1ps
module tb_fpx_widen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_fmt;
  logic [63:0] in_word;
  logic        out_valid;
  logic [79:0] out_word;
  logic        out_zero, out_inf, out_nan, out_denorm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fpx_widen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_word(in_word), .out_valid(out_valid), .out_word(out_word),
    .out_zero(out_zero), .out_inf(out_inf), .out_nan(out_nan),
    .out_denorm(out_denorm)
  );

  // returns {zero, inf, nan, denorm, word80}
  function automatic logic [83:0] model(input logic fmt, input logic [63:0] w);
    int          fb, bias, e, xe;
    logic [63:0] f, sig;
    logic        s, ones;
    logic [3:0]  fl;
    if (fmt) begin
      fb = 52; bias = 1023; s = w[63]; e = int'(w[62:52]);
      f = {12'b0, w[51:0]}; ones = (e == 2047);
    end else begin
      fb = 23; bias = 127; s = w[31]; e = int'(w[30:23]);
      f = {41'b0, w[22:0]}; ones = (e == 255);
    end
    fl = 4'b0000;
    if (e == 0 && f == 0) begin
      xe = 0; sig = 64'd0; fl = 4'b1000;
    end else if (ones && f == 0) begin
      xe = 32767; sig = 64'h8000_0000_0000_0000; fl = 4'b0100;
    end else if (ones) begin
      xe = 32767; sig = 64'hC000_0000_0000_0000 | (f << (63 - fb)); fl = 4'b0010;
    end else if (e == 0) begin
      sig = f << (63 - fb);
      xe  = 1 - bias + 16383;
      while (!sig[63]) begin
        sig = sig << 1;
        xe  = xe - 1;
      end
      fl = 4'b0001;
    end else begin
      xe = e - bias + 16383; sig = 64'h8000_0000_0000_0000 | (f << (63 - fb));
    end
    return {fl, s, xe[14:0], sig};
  endfunction

  function automatic string tag_of(input logic fmt, input logic [83:0] m);
    if (m[83]) return "R4";
    if (m[82]) return "R5";
    if (m[81]) return "R6";
    if (m[80]) return "R7";
    return fmt ? "R3" : "R2";
  endfunction

  task automatic check(input string tag, input logic [83:0] act, input logic [83:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic fmt, input logic [63:0] w, input string tag);
    logic [83:0] m;
    @(negedge clk);
    in_valid = 1'b1; in_fmt = fmt; in_word = w;
    m = model(fmt, w);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag.len() ? tag : tag_of(fmt, m),
          {out_zero, out_inf, out_nan, out_denorm, out_word}, m);
    check("R1", {83'd0, out_word[79]}, {83'd0, m[79]});
    check("R8", {83'd0, out_valid}, 84'd1);
  endtask

  function automatic logic [63:0] rnd_word(input logic fmt);
    int          k;
    logic [63:0] f, r;
    logic [10:0] e;
    logic        s;
    int          fb;
    k  = int'($urandom % 6);
    s  = $urandom % 2;
    fb = fmt ? 52 : 23;
    r  = {$urandom, $urandom};
    f  = r & ((64'd1 << fb) - 1);
    e  = 11'($urandom);
    if (!fmt) e = {3'b0, e[7:0]};
    case (k)
      0: e = 0;
      1: begin e = fmt ? 11'h7FF : 11'hFF; if ($urandom % 2) f = 0; end
      3: begin e = 0; f = 0; end
      4: begin e = 0; f = (64'd1 << ($urandom % fb)); f = f | (r & (f - 1)); end
      default: if (e == 0) e = 1;
    endcase
    if (k == 5) return r;
    if (fmt) return {s, e, f[51:0]};
    return {r[63:32], s, e[7:0], f[22:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [79:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_fmt = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    check("R8", {83'd0, out_valid}, 84'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", {83'd0, out_valid}, 84'd0);

    apply(1'b0, 64'h0000_0000_42C8_8000, "R2");
    check("R2", {4'd0, out_word}, {4'd0, 80'h4005_C880_0000_0000_0000});
    apply(1'b1, 64'h4059_1000_0000_0000, "R3");
    apply(1'b0, 64'h0000_0000_8000_0000, "R4");
    apply(1'b1, 64'h0000_0000_0000_0000, "R4");
    apply(1'b1, 64'h7FF0_0000_0000_0000, "R5");
    apply(1'b0, 64'h0000_0000_FF80_0000, "R5");
    apply(1'b0, 64'h0000_0000_7F80_0001, "R6");
    apply(1'b1, 64'hFFF0_0000_0000_0001, "R6");
    apply(1'b0, 64'h0000_0000_0000_0001, "R7");
    apply(1'b0, 64'h0000_0000_007F_FFFF, "R7");
    apply(1'b1, 64'h0000_0000_0000_0001, "R7");
    apply(1'b1, 64'h800F_FFFF_FFFF_FFFF, "R7");
    apply(1'b0, 64'hDEAD_BEEF_3F80_0000, "R9");
    check("R9", {4'd0, out_word}, {4'd0, 80'h3FFF_8000_0000_0000_0000});
    apply(1'b1, 64'h3FF0_0000_0000_0000, "R9");

    // hold while idle
    held = out_word;
    @(negedge clk);
    in_word = 64'h7FF8_1234_5678_9ABC; in_fmt = 1'b1;
    @(negedge clk);
    check("R10", {4'd0, out_word}, {4'd0, held});
    check("R8", {83'd0, out_valid}, 84'd0);

    for (int i = 0; i < 400; i++) begin
      logic fm;
      fm = $urandom % 2;
      apply(fm, rnd_word(fm), "");
      total++;
      if ($countones({out_zero, out_inf, out_nan, out_denorm}) > 1) begin
        bad++;
        $display("FAIL R10 flags=%b exp=onehot0", {out_zero, out_inf, out_nan, out_denorm});
      end
    end

    // reset mid-run clears valid
    @(negedge clk);
    in_valid = 1'b1; in_word = 64'h3F80_0000;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    check("R8", {83'd0, out_valid}, 84'd0);
    rst_n = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule